// File: doc/BRIEF.md
# Differencing Multistage Interference Canceller

This block makes bit decisions for K users who share a channel at the same time, using a chain of interference-cancellation stages. Each decision interval, the caller presents one vector of signed matched-filter outputs, with one entry per user. Before that, the caller loads a real cross-correlation matrix whose off-diagonal entries describe how much each user leaks into every other user. The first decisions are simply the signs of the matched-filter outputs. Each later stage takes its soft values and removes the interference predicted from the current decisions.

From the second cancellation stage on, a stage does not subtract the full interference estimate. It subtracts only the correction caused by decisions that flipped since the stage before. In a ±1 alphabet, a decision difference is 0 or ±2, so every multiply becomes a skip, or the add or subtract of a matrix entry shifted by one bit. Each stage walks the K matrix columns one per clock, with all K rows updated in parallel. The stages form a pipeline, so one stage works on a new interval while the next stage finishes the previous one.

The caller writes the matrix one column at a time. It then issues vectors no closer together than K cycles. After a fixed latency, it collects the final decisions, the saturated final soft values and the decision history of every stage.

Top module: `mud_canceller`

## Requirements
- R1: A decision bit of 0 means +1 and a bit of 1 means −1. A soft value that is negative gives 1, and zero or positive gives 0. The stage-0 decisions are the signs of the input vector, where user r's input is `in_soft[r*MF_W +: MF_W]` (two's complement).
- R2: Stage 1 soft value for user r is y0[r] − Σ_{c≠r} M[r][c]·s0[c], where s0[c] is the ±1 value of the stage-0 decision of user c.
- R3: For stage l from 2 to NS, the soft value is y_{l−1}[r] − Σ_{c≠r} M[r][c]·(s_{l−1}[c] − s_{l−2}[c]). Every stage's decisions are the signs of its soft values. `out_soft` and `out_dec` carry stage NS.
- R4: Diagonal entries of the matrix have no effect on any result, whatever value is loaded there.
- R5: Within a stage the sums are exact. Each stage's soft values are saturated to the MF_W-bit signed range [−2^(MF_W−1), 2^(MF_W−1)−1] before the next stage uses them and before output.
- R6: `out_valid` is high for exactly one cycle, NS·K rising edges after the edge that accepts an input vector. `out_soft`, `out_dec` and `out_dec_hist` change only in that cycle and hold between pulses.
- R7: An input vector is accepted when stage 1 is idle or is on its last column. A vector offered while stage 1 is mid-pass is dropped and produces no output. Vectors accepted exactly K cycles apart both complete, in order, K cycles apart.
- R8: `out_dec_hist` holds the decisions of stage l in bits [l*K +: K], for l = 0 to NS. Its top slot equals `out_dec`.
- R9: While reset is high and after it is released, `out_valid`, `out_dec`, `out_dec_hist` and `out_soft` are zero until the first result.
- R10: A write with `cfg_we` high stores column `cfg_col`, with entry M[r][col] taken from `cfg_data[r*C_W +: C_W]` (two's complement). It applies to every vector accepted after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Matrix column write enable |
| cfg_col | input | $clog2(K) | Column index to write |
| cfg_data | input | K*C_W | Column entries, row r at [r*C_W +: C_W] |
| in_valid | input | 1 | Input vector offered this cycle |
| in_soft | input | K*MF_W | Matched-filter outputs, user r at [r*MF_W +: MF_W] |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_dec | output | K | Final decisions, 1 = −1 |
| out_dec_hist | output | (NS+1)*K | Decisions of every stage, stage l at [l*K +: K] |
| out_soft | output | K*MF_W | Final saturated soft values |

## Verification
A vector is accepted on a rising edge. Each of the NS stages then spends K edges walking the matrix columns, and the output register loads on the edge where the last stage finishes. Every result is therefore due exactly NS·K edges after acceptance (24 with the default parameters). The bench counts that many edges and samples on the falling edge after them. It also confirms that `out_valid` is still low one edge earlier. The drop and back-to-back cases sample every falling edge over the whole window, to check that pulses appear only on the edges that R7 predicts.

// File: rtl/mud_pkg.sv
package mud_pkg;

  // Term applied to one accumulator for one matrix column.
  typedef enum logic [1:0] {
    OP_SKIP = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } term_op_e;

  // Accumulator width: room for the input, plus K terms of a doubled entry.
  function automatic int acc_width(int mf_w, int c_w, int k);
    int base;
    base = (mf_w > c_w + 1) ? mf_w : c_w + 1;
    return base + $clog2(k) + 2;
  endfunction

endpackage

// File: rtl/mud_col_ram.sv
module mud_col_ram #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 80,
  parameter int ADW   = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [ADW-1:0]   waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [ADW-1:0]   raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Single write port, registered read: maps onto one block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/mud_stage.sv
module mud_stage
  import mud_pkg::*;
#(
  parameter int K     = 8,
  parameter int MF_W  = 12,
  parameter int C_W   = 10,
  parameter int NS    = 3,
  parameter int STAGE = 1,
  parameter int AW    = 17,
  parameter int CIW   = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [K*MF_W-1:0]     soft_in,
  input  logic [K-1:0]          dnew_in,
  input  logic [K-1:0]          dold_in,
  input  logic [(NS+1)*K-1:0]   hist_in,
  input  logic [K*C_W-1:0]      col_data,
  output logic [CIW-1:0]        rd_col,
  output logic                  ready,
  output logic                  done,
  output logic [K*MF_W-1:0]     soft_out,
  output logic [K-1:0]          dec_out,
  output logic [(NS+1)*K-1:0]   hist_out
);

  localparam bit FIRST = (STAGE == 1);
  localparam logic signed [AW-1:0] SAT_HI = AW'((2 ** (MF_W - 1)) - 1);
  localparam logic signed [AW-1:0] SAT_LO = -SAT_HI - AW'(1);
  localparam logic [CIW-1:0] LAST_COL = CIW'(K - 1);

  logic                 busy;
  logic [CIW-1:0]       col;
  logic signed [AW-1:0] acc    [K];
  logic signed [AW-1:0] acc_nx [K];
  logic [K-1:0]         dnew, dold;
  logic [(NS+1)*K-1:0]  hist;
  term_op_e             op;

  assign done   = busy && (col == LAST_COL);
  assign ready  = !busy || done;
  // Prefetch: column c is read one cycle before it is consumed.
  assign rd_col = (busy && !done) ? col + CIW'(1) : '0;

  // The decision change of the current column's user selects the term.
  always_comb begin
    if (!FIRST && (dnew[col] == dold[col])) op = OP_SKIP;
    else if (dnew[col])                     op = OP_ADD;
    else                                    op = OP_SUB;
  end

  for (genvar r = 0; r < K; r++) begin : g_row
    logic signed [C_W-1:0] entry;
    logic signed [AW-1:0]  ext;
    logic signed [AW-1:0]  term;
    logic                  diag;

    assign entry = col_data[r*C_W +: C_W];
    assign ext   = AW'(entry);
    assign diag  = (col == CIW'(r));

    if (FIRST) begin : g_unit
      assign term = ext;
    end else begin : g_dbl
      assign term = ext <<< 1;
    end

    always_comb begin
      acc_nx[r] = acc[r];
      if (!diag) begin
        case (op)
          OP_ADD:  acc_nx[r] = acc[r] + term;
          OP_SUB:  acc_nx[r] = acc[r] - term;
          default: acc_nx[r] = acc[r];
        endcase
      end
    end

    always_comb begin
      if (acc_nx[r] > SAT_HI)      soft_out[r*MF_W +: MF_W] = SAT_HI[MF_W-1:0];
      else if (acc_nx[r] < SAT_LO) soft_out[r*MF_W +: MF_W] = SAT_LO[MF_W-1:0];
      else                         soft_out[r*MF_W +: MF_W] = acc_nx[r][MF_W-1:0];
    end

    assign dec_out[r] = acc_nx[r][AW-1];
  end

  always_comb begin
    hist_out = hist;
    hist_out[STAGE*K +: K] = dec_out;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      col  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      col  <= '0;
    end else if (busy) begin
      col <= col + CIW'(1);
      if (done) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      for (int r = 0; r < K; r++) acc[r] <= AW'($signed(soft_in[r*MF_W +: MF_W]));
      dnew <= dnew_in;
      dold <= dold_in;
      hist <= hist_in;
    end else if (busy) begin
      for (int r = 0; r < K; r++) acc[r] <= acc_nx[r];
    end
  end

endmodule

// File: rtl/mud_canceller.sv
module mud_canceller
  import mud_pkg::*;
#(
  parameter int K    = 8,
  parameter int MF_W = 12,
  parameter int C_W  = 10,
  parameter int NS   = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cfg_we,
  input  logic [$clog2(K)-1:0]         cfg_col,
  input  logic [K*C_W-1:0]             cfg_data,
  input  logic                         in_valid,
  input  logic [K*MF_W-1:0]            in_soft,
  output logic                         out_valid,
  output logic [K-1:0]                 out_dec,
  output logic [(NS+1)*K-1:0]          out_dec_hist,
  output logic [K*MF_W-1:0]            out_soft
);

  localparam int CIW = $clog2(K);
  localparam int AW  = acc_width(MF_W, C_W, K);
  localparam int HW  = (NS + 1) * K;

  logic [K*MF_W-1:0] ch_soft [NS+1];
  logic [K-1:0]      ch_dec  [NS+1];
  logic [HW-1:0]     ch_hist [NS+1];
  logic [NS:0]       ch_done;
  logic [NS:1]       rdy;
  logic              accept;

  // Stage 0: sign decision on the matched-filter outputs.
  for (genvar r = 0; r < K; r++) begin : g_sign0
    assign ch_dec[0][r] = in_soft[r*MF_W + MF_W - 1];
  end

  assign accept     = in_valid && rdy[1];
  assign ch_done[0] = accept;
  assign ch_soft[0] = in_soft;
  assign ch_hist[0] = HW'(ch_dec[0]);

  for (genvar s = 1; s <= NS; s++) begin : g_stage
    logic [K-1:0]     old_dec;
    logic [CIW-1:0]   rd_col;
    logic [K*C_W-1:0] col_data;

    if (s == 1) begin : g_old_first
      assign old_dec = ~ch_dec[0];
    end else begin : g_old_hist
      assign old_dec = ch_hist[s-1][(s-2)*K +: K];
    end

    mud_col_ram #(
      .DEPTH (K),
      .WIDTH (K*C_W),
      .ADW   (CIW)
    ) i_ram (
      .clk   (clk),
      .we    (cfg_we),
      .waddr (cfg_col),
      .wdata (cfg_data),
      .raddr (rd_col),
      .rdata (col_data)
    );

    mud_stage #(
      .K     (K),
      .MF_W  (MF_W),
      .C_W   (C_W),
      .NS    (NS),
      .STAGE (s),
      .AW    (AW),
      .CIW   (CIW)
    ) i_stage (
      .clk      (clk),
      .rst      (rst),
      .start    (ch_done[s-1] && rdy[s]),
      .soft_in  (ch_soft[s-1]),
      .dnew_in  (ch_dec[s-1]),
      .dold_in  (old_dec),
      .hist_in  (ch_hist[s-1]),
      .col_data (col_data),
      .rd_col   (rd_col),
      .ready    (rdy[s]),
      .done     (ch_done[s]),
      .soft_out (ch_soft[s]),
      .dec_out  (ch_dec[s]),
      .hist_out (ch_hist[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_dec      <= '0;
      out_dec_hist <= '0;
      out_soft     <= '0;
    end else begin
      out_valid <= ch_done[NS];
      if (ch_done[NS]) begin
        out_dec      <= ch_dec[NS];
        out_dec_hist <= ch_hist[NS];
        out_soft     <= ch_soft[NS];
      end
    end
  end

endmodule

// File: rtl/mud_canceller_chk.sv
module mud_canceller_chk #(
  parameter int K    = 8,
  parameter int MF_W = 12,
  parameter int NS   = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  accept,
  input logic                  out_valid,
  input logic [K-1:0]          out_dec,
  input logic [(NS+1)*K-1:0]   out_dec_hist,
  input logic [K*MF_W-1:0]     out_soft
);

  localparam int LAT = NS * K;

  logic [LAT:0] pend;

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= {pend[LAT-1:0], accept};
  end

  function automatic logic [K-1:0] signs(input logic [K*MF_W-1:0] v);
    logic [K-1:0] s;
    for (int r = 0; r < K; r++) s[r] = v[r*MF_W + MF_W - 1];
    return s;
  endfunction

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst) out_valid == pend[LAT]); // R6
  AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (rst) !out_valid |-> ($stable(out_soft) && $stable(out_dec))); // R6
  AST_DEC_IS_SIGN: assert property (@(posedge clk) disable iff (rst) out_valid |-> out_dec == signs(out_soft)); // R1
  AST_HIST_TOP_SLOT: assert property (@(posedge clk) disable iff (rst) out_valid |-> out_dec == out_dec_hist[NS*K +: K]); // R8
  AST_PULSE_SPACING: assert property (@(posedge clk) disable iff (rst) out_valid |=> !out_valid); // R7
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !out_valid); // R9

endmodule

bind mud_canceller mud_canceller_chk #(.K(K), .MF_W(MF_W), .NS(NS)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .accept       (accept),
  .out_valid    (out_valid),
  .out_dec      (out_dec),
  .out_dec_hist (out_dec_hist),
  .out_soft     (out_soft)
);

// File: tb/test_mud_canceller.sv
module test_mud_canceller;

  localparam int K    = 8;
  localparam int MF_W = 12;
  localparam int C_W  = 10;
  localparam int NS   = 3;
  localparam int CIW  = $clog2(K);
  localparam int LAT  = NS * K;
  localparam int HW   = (NS + 1) * K;
  localparam int SMAX = 2 ** (MF_W - 1) - 1;
  localparam int SMIN = -(2 ** (MF_W - 1));

  // Each row: pattern kind (0 pseudo, 1 all max, 2 all min, 3 zero), seed, matrix id.
  localparam int NVEC = 8;
  localparam int TBL [NVEC][3] = '{
    '{0, 1, 0},
    '{0, 2, 0},
    '{0, 3, 1},
    '{1, 0, 2},
    '{2, 0, 2},
    '{3, 0, 3},
    '{0, 4, 3},
    '{0, 5, 0}
  };

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                cfg_we = 1'b0;
  logic [CIW-1:0]      cfg_col = '0;
  logic [K*C_W-1:0]    cfg_data = '0;
  logic                in_valid = 1'b0;
  logic [K*MF_W-1:0]   in_soft = '0;
  logic                out_valid;
  logic [K-1:0]        out_dec;
  logic [HW-1:0]       out_dec_hist;
  logic [K*MF_W-1:0]   out_soft;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  int mat [K][K];
  int in_y [K];
  logic [K*MF_W-1:0] exp_soft;
  logic [K-1:0]      exp_dec;
  logic [HW-1:0]     exp_hist;

  always #5 clk = ~clk;

  mud_canceller #(.K(K), .MF_W(MF_W), .C_W(C_W), .NS(NS)) i_mud_canceller (
    .clk          (clk),
    .rst          (rst),
    .cfg_we       (cfg_we),
    .cfg_col      (cfg_col),
    .cfg_data     (cfg_data),
    .in_valid     (in_valid),
    .in_soft      (in_soft),
    .out_valid    (out_valid),
    .out_dec      (out_dec),
    .out_dec_hist (out_dec_hist),
    .out_soft     (out_soft)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int gen_entry(input int id, input int r, input int c);
    case (id)
      0, 1:    return (r == c) ? 300 : ((r*29 + c*13 + id*71 + r*c*7) % 301) - 150;
      2:       return (r == c) ? 0 : -500;
      default: return (r == c) ? 511 : 0;
    endcase
  endfunction

  function automatic int sat(input int v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  // R10: column write, row r entry at cfg_data[r*C_W +: C_W].
  task automatic load_matrix(input int id);
    for (int r = 0; r < K; r++)
      for (int c = 0; c < K; c++) mat[r][c] = gen_entry(id, r, c);
    for (int c = 0; c < K; c++) begin
      @(negedge clk);
      cfg_we  = 1'b1;
      cfg_col = CIW'(c);
      for (int r = 0; r < K; r++) cfg_data[r*C_W +: C_W] = C_W'(mat[r][c]);
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic make_vec(input int kind, input int seed);
    for (int r = 0; r < K; r++) begin
      case (kind)
        0:       in_y[r] = ((seed*173 + r*911 + r*r*37) % 4001) - 2000;
        1:       in_y[r] = SMAX;
        2:       in_y[r] = SMIN;
        default: in_y[r] = 0;
      endcase
    end
  endtask

  // Expected values from R1, R2, R3, R4, R5.
  task automatic compute_expected();
    int cur [K];
    int nxt [K];
    bit dcur [K];
    bit dprev [K];
    exp_hist = '0;
    for (int r = 0; r < K; r++) begin
      cur[r]   = in_y[r];
      dcur[r]  = (cur[r] < 0);
      dprev[r] = 1'b0;
      exp_hist[r] = dcur[r];
    end
    for (int l = 1; l <= NS; l++) begin
      for (int r = 0; r < K; r++) begin
        int acc;
        acc = cur[r];
        for (int c = 0; c < K; c++) begin
          if (c != r) begin
            int delta;
            delta = dcur[c] ? -1 : 1;
            if (l > 1) delta = delta - (dprev[c] ? -1 : 1);
            acc = acc - mat[r][c] * delta;
          end
        end
        nxt[r] = sat(acc);
      end
      for (int r = 0; r < K; r++) begin
        dprev[r] = dcur[r];
        cur[r]   = nxt[r];
        dcur[r]  = (cur[r] < 0);
        exp_hist[l*K + r] = dcur[r];
      end
    end
    for (int r = 0; r < K; r++) begin
      exp_soft[r*MF_W +: MF_W] = MF_W'(cur[r]);
      exp_dec[r] = dcur[r];
    end
  endtask

  task automatic drive_vec();
    for (int r = 0; r < K; r++) in_soft[r*MF_W +: MF_W] = MF_W'(in_y[r]);
  endtask

  task automatic check_result(input string tag);
    chk(out_valid == 1'b1, {tag, " R6 valid"}, 128'(out_valid), 128'(1));
    chk(out_soft == exp_soft, {tag, " R3 soft"}, 128'(out_soft), 128'(exp_soft));
    chk(out_dec == exp_dec, {tag, " R1 dec"}, 128'(out_dec), 128'(exp_dec));
    chk(out_dec_hist == exp_hist, {tag, " R8 hist"}, 128'(out_dec_hist), 128'(exp_hist));
  endtask

  // Watchdog: a hang counts as one failed check.
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R6 watchdog actual=hang expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int cur_mat;
    int pulses;
    int pulse_at;
    logic [K*MF_W-1:0] soft_a;
    logic [K*MF_W-1:0] soft_b;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(out_valid == 1'b0, "R9 reset valid", 128'(out_valid), 128'(0));
    chk(out_soft == '0 && out_dec == '0 && out_dec_hist == '0, "R9 reset data",
        128'(out_soft), 128'(0));
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 after release", 128'(out_valid), 128'(0));

    cur_mat = -1;
    for (int i = 0; i < NVEC; i++) begin
      if (TBL[i][2] != cur_mat) begin
        cur_mat = TBL[i][2];
        load_matrix(cur_mat);  // R10: new matrix applies to later vectors
      end
      make_vec(TBL[i][0], TBL[i][1]);
      compute_expected();
      @(negedge clk);
      drive_vec();
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (LAT - 1) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, $sformatf("vec%0d R6 early", i), 128'(out_valid), 128'(0));
      @(posedge clk);
      @(negedge clk);
      check_result($sformatf("vec%0d", i));
      @(negedge clk);
      chk(out_valid == 1'b0, $sformatf("vec%0d R6 pulse", i), 128'(out_valid), 128'(0));
    end

    // R4: diagonal-only matrix passes inputs through untouched
    load_matrix(3);
    make_vec(0, 11);
    compute_expected();
    for (int r = 0; r < K; r++) exp_soft[r*MF_W +: MF_W] = MF_W'(in_y[r]);
    @(negedge clk);
    drive_vec();
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT) @(posedge clk);
    @(negedge clk);
    chk(out_soft == exp_soft, "R4 diagonal ignored", 128'(out_soft), 128'(exp_soft));

    // R5: saturation to the MF_W range
    load_matrix(2);
    make_vec(1, 0);
    @(negedge clk);
    drive_vec();
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (LAT) @(posedge clk);
    @(negedge clk);
    exp_soft = '0;
    for (int r = 0; r < K; r++) exp_soft[r*MF_W +: MF_W] = MF_W'(SMAX);
    chk(out_soft == exp_soft, "R5 saturate high", 128'(out_soft), 128'(exp_soft));

    // R7: a vector offered mid-pass is dropped
    load_matrix(0);
    make_vec(0, 7);
    compute_expected();
    soft_a = exp_soft;
    @(negedge clk);
    drive_vec();
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    make_vec(0, 9);
    drive_vec();
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    pulses = 0;
    pulse_at = 0;
    for (int e = 2; e <= 5 * K; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (out_valid) begin
        pulses++;
        pulse_at = e;
        if (pulses == 1)
          chk(out_soft == soft_a, "R7 kept vector result", 128'(out_soft), 128'(soft_a));
      end
    end
    chk(pulses == 1, "R7 dropped vector count", 128'(pulses), 128'(1));
    chk(pulse_at == LAT, "R7 kept vector timing", 128'(pulse_at), 128'(LAT));

    // R7: back-to-back vectors exactly K cycles apart
    make_vec(0, 13);
    compute_expected();
    soft_a = exp_soft;
    make_vec(0, 17);
    compute_expected();
    soft_b = exp_soft;
    make_vec(0, 13);
    @(negedge clk);
    drive_vec();
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (K - 1) @(posedge clk);
    @(negedge clk);
    make_vec(0, 17);
    drive_vec();
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2 * K - 1) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 first not early", 128'(out_valid), 128'(0));
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b1 && out_soft == soft_a, "R7 first result", 128'(out_soft), 128'(soft_a));
    repeat (K - 1) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 gap between results", 128'(out_valid), 128'(0));
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b1 && out_soft == soft_b, "R7 second result", 128'(out_soft), 128'(soft_b));

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule